// File: doc/BRIEF.md
# UART Modem Handshake Register Block

This block holds the modem-handshake part of a UART register file. It brings in the four active-low modem lines (clear-to-send, data-set-ready, ring indicator and carrier detect) through two-flop synchronizers. It reports their asserted state together with sticky change flags in a read-only status register. It raises a modem-status interrupt request when enabled, and drives the active-low terminal-ready output from a writable control register.

The CPU side is a synchronous register port with a 3-bit address, write data, read data, a read strobe and a write strobe. The block answers only when a three-line chip select is in its selecting combination. A driver-disable output goes high for as long as a selected read is in progress, so an external bus transceiver can be turned around. A read of the status register returns the current flags and clears them, together with the interrupt request, at the clock edge that ends the read. The clear-to-send level is also exported as a transmit-permit signal for hardware flow control. A clear-to-send change does not interrupt the CPU while that flow control is active.

Top module: `uart_modem_ctl`

## Requirements
- R1: After the synchronous master reset (`rst_n` low at a clock edge), the control register reads 0x00, `dtr_n` is 1, `loop_mode` is 0, `msi_req` is 0, and every change flag reads 0.
- R2: The status register is at address 6. Bits 4, 5, 6 and 7 report CTS, DSR, RI and DCD as asserted, so a low pin reads 1. A pin change shows in these bits within three clock edges.
- R3: Status bits 0, 1 and 3 are set when CTS, DSR or DCD, respectively, has changed level in either direction since the last status read.
- R4: Status bit 2 is set only when RI goes from low to high (becomes inactive). A high-to-low RI change leaves bit 2 at 0.
- R5: A selected read of address 6 clears all change flags and `msi_req` at the clock edge that ends the read, unless a new change arrives in that cycle.
- R6: With `msi_en` high, a DSR change, a DCD change or an RI trailing edge sets `msi_req`. With `msi_en` low, no change sets it.
- R7: `tx_permit` equals the asserted state of CTS. A CTS change sets `msi_req` only when `msi_en` is 1 and `auto_cts_en` is 0, but it always sets status bit 0.
- R8: The control register is at address 4. Bits 4..0 can be written and bits 7..5 read 0. `dtr_n` is low exactly when bit 0 is 1 and bit 4 (loop) is 0. `loop_mode` follows bit 4.
- R9: The block is selected only when `cs_a`=1, `cs_b`=1 and `cs_c_n`=0. Otherwise a write changes nothing, `rd_data` is 0x00, and a read of address 6 does not clear the flags or `msi_req`.
- R10: `drv_dis` is 1 exactly while a selected read strobe is high, and 0 otherwise.
- R11: Once set, `msi_req` stays at 1 until a selected status read or a master reset.
- R12: Writes to address 6 are ignored. A selected read of any address other than 4 or 6 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Read data, combinational during a selected read |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_cts_en | input | 1 | Hardware CTS flow control active |
| dtr_n | output | 1 | Terminal-ready output, active low |
| loop_mode | output | 1 | Loopback mode bit to the serial datapath |
| tx_permit | output | 1 | Synchronized asserted CTS for the transmitter |
| msi_req | output | 1 | Modem-status interrupt request |
| drv_dis | output | 1 | High during a selected read |

## Verification
A wrong synchronizer or previous-sample register shows up at the ports as a status read with a wrong level or change bit. It appears at the first read that follows a pin change, no more than three edges after the pin moves. A wrong flag clear or interrupt mask shows up in the next status read or on `msi_req` one edge after the event. The interrupt case is checked with the enable off, with flow control on, and across unselected reads. A wrong control-register bit shows at once on `dtr_n` and `loop_mode`, and in the readback value.

// File: rtl/uart_modem_pkg.sv
// Shared constants for the modem handshake block.
// Assumes an 8-bit data bus and four modem lines. The index of each line is
// both its change-flag bit and (plus NUM_LINES) its level bit.
package uart_modem_pkg;
    localparam int NUM_LINES = 4;
    localparam int LINE_CTS  = 0;
    localparam int LINE_DSR  = 1;
    localparam int LINE_RI   = 2;
    localparam int LINE_DCD  = 3;

    localparam int REG_CTRL   = 4;
    localparam int REG_STATUS = 6;

    localparam int CTRL_DTR_BIT  = 0;
    localparam int CTRL_LOOP_BIT = 4;
    localparam int CTRL_BITS     = 5;
endpackage

// File: rtl/modem_sync.sv
// Two-or-more-stage synchronizer for the active-low modem lines, plus one
// extra sample used for change detection.
// Assumes the pins idle high; all stages reset to 1 so reset makes no change.
module modem_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_n,
    output logic [WIDTH-1:0] sync_n,
    output logic [WIDTH-1:0] prev_n
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '1;
        else        stage_q[0] <= pins_n;
    end

    // Remaining stages settle metastability.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= '1;
        else        prev_n <= stage_q[STAGES-1];
    end

    assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/modem_status.sv
// Modem status register: level bits, sticky change flags and the
// modem-status interrupt request.
// Assumes clr_req is a one-cycle selected read of the status address;
// a change arriving in the clearing cycle is kept.
module modem_status
    import uart_modem_pkg::*;
#(
    parameter int WIDTH = NUM_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_n,
    input  logic [WIDTH-1:0] prev_n,
    input  logic             clr_req,
    input  logic             msi_en,
    input  logic             auto_cts_en,
    output logic [2*WIDTH-1:0] status,
    output logic             msi_req
);
    logic [WIDTH-1:0] chg;
    logic [WIDTH-1:0] irq_mask;
    logic [WIDTH-1:0] flag_q;
    logic             irq_evt;

    // Per-line change detect: RI on its trailing edge only, others on any edge.
    for (genvar i = 0; i < WIDTH; i++) begin : g_chg
        if (i == LINE_RI) begin : g_trail
            assign chg[i] = ~prev_n[i] & sync_n[i];
        end else begin : g_any
            assign chg[i] = prev_n[i] ^ sync_n[i];
        end
    end

    // Interrupt mask: CTS is excluded while hardware flow control owns it.
    always_comb begin
        irq_mask = '1;
        if (auto_cts_en) irq_mask[LINE_CTS] = 1'b0;
    end

    assign irq_evt = msi_en & |(chg & irq_mask);

    // Sticky change flags, cleared by a status read, new changes win.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (clr_req ? '0 : flag_q) | chg;
    end

    // Interrupt request held until serviced by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) msi_req <= 1'b0;
        else        msi_req <= (msi_req & ~clr_req) | irq_evt;
    end

    assign status = {~sync_n, flag_q};

    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && chg == '0) |=> (flag_q == '0 && !msi_req));
    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !clr_req) |=> msi_req);
    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_req && !msi_en) |=> !msi_req);
    assert_cts_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_req && auto_cts_en && !chg[LINE_DSR] && !chg[LINE_RI] && !chg[LINE_DCD])
        |=> !msi_req);
endmodule

// File: rtl/bus_select.sv
// Chip-select decode and bus driver-disable generation.
// Assumes strobes are synchronous to clk; outputs are combinational.
module bus_select (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_a,
    input  logic cs_b,
    input  logic cs_c_n,
    input  logic rd_en,
    input  logic wr_en,
    output logic sel_rd,
    output logic sel_wr,
    output logic drv_dis
);
    logic sel;

    // Decode the three-line select into one enable.
    always_comb begin
        sel    = cs_a & cs_b & ~cs_c_n;
        sel_rd = sel & rd_en;
        sel_wr = sel & wr_en;
    end

    assign drv_dis = sel_rd;

    assert_drv_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || cs_c_n) |-> !drv_dis);
endmodule

// File: rtl/uart_modem_ctl.sv
// Top of the modem handshake block: control register, read mux and
// instances of the select decode, synchronizer and status logic.
// Assumes a synchronous active-low master reset and single-cycle strobes.
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              dcd_n,
    input  logic              ri_n,
    input  logic              msi_en,
    input  logic              auto_cts_en,
    output logic              dtr_n,
    output logic              loop_mode,
    output logic              tx_permit,
    output logic              msi_req,
    output logic              drv_dis
);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_BITS) - 1);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(REG_STATUS);

    logic                   sel_rd, sel_wr;
    logic [NUM_LINES-1:0]   pins_n, sync_n, prev_n;
    logic [2*NUM_LINES-1:0] status;
    logic [DATA_W-1:0]      ctrl_q;
    logic                   clr_req;

    bus_select u_sel (
        .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .rd_en(rd_en), .wr_en(wr_en), .sel_rd(sel_rd), .sel_wr(sel_wr),
        .drv_dis(drv_dis)
    );

    // Gather the pins in line-index order.
    always_comb begin
        pins_n           = '1;
        pins_n[LINE_CTS] = cts_n;
        pins_n[LINE_DSR] = dsr_n;
        pins_n[LINE_RI]  = ri_n;
        pins_n[LINE_DCD] = dcd_n;
    end

    modem_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins_n(pins_n), .sync_n(sync_n), .prev_n(prev_n)
    );

    assign clr_req = sel_rd && (addr == A_STATUS);

    modem_status #(.WIDTH(NUM_LINES)) u_stat (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .prev_n(prev_n),
        .clr_req(clr_req), .msi_en(msi_en), .auto_cts_en(auto_cts_en),
        .status(status), .msi_req(msi_req)
    );

    // Control register: written only at its own address when selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ctrl_q <= '0;
        else if (sel_wr && addr == A_CTRL) ctrl_q <= wr_data & CTRL_MASK;
    end

    // Read mux: zero unless a selected read hits a known register.
    always_comb begin
        rd_data = '0;
        if (sel_rd) begin
            if (addr == A_STATUS)    rd_data = DATA_W'(status);
            else if (addr == A_CTRL) rd_data = ctrl_q;
        end
    end

    assign loop_mode = ctrl_q[CTRL_LOOP_BIT];
    assign dtr_n     = ~(ctrl_q[CTRL_DTR_BIT] & ~ctrl_q[CTRL_LOOP_BIT]);
    assign tx_permit = ~sync_n[LINE_CTS];

    assert_unselected_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(ctrl_q));
    assert_loop_forces_dtr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode |-> dtr_n);
endmodule

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_a = 1'b1, cs_b = 1'b1, cs_c_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] rd_data;
    logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
    logic       msi_en = 1'b0, auto_cts_en = 1'b0;
    logic       dtr_n, loop_mode, tx_permit, msi_req, drv_dis;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_modem_ctl dut (
        .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .addr(addr), .wr_data(wr_data), .rd_en(rd_en), .wr_en(wr_en),
        .rd_data(rd_data), .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n),
        .ri_n(ri_n), .msi_en(msi_en), .auto_cts_en(auto_cts_en), .dtr_n(dtr_n),
        .loop_mode(loop_mode), .tx_permit(tx_permit), .msi_req(msi_req),
        .drv_dis(drv_dis)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Selected or not as cs lines stand; returns data and drv_dis seen mid-read.
    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d, output logic dd);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rd_data; dd = drv_dis;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic dd;
        rst_n = 1'b0; wait_clk(4); rst_n = 1'b1; wait_clk(1);
        chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
        chk("R1 msi_req", {7'd0, msi_req}, 8'h00);
        chk("R1 loop", {7'd0, loop_mode}, 8'h00);
        chk("R10 drv_dis idle", {7'd0, drv_dis}, 8'h00);
        reg_rd(3'd4, d, dd); chk("R1 ctrl", d, 8'h00);
        reg_rd(3'd6, d, dd); chk("R1 status", d, 8'h00);
        chk("R10 drv_dis in read", {7'd0, dd}, 8'h01);
    endtask

    task automatic t_levels;
        logic [7:0] d; logic dd;
        @(negedge clk); cts_n = 1'b0; wait_clk(4);
        chk("R7 tx_permit", {7'd0, tx_permit}, 8'h01);
        reg_rd(3'd6, d, dd); chk("R3 cts change", d, 8'h11);
        reg_rd(3'd6, d, dd); chk("R5 flags cleared", d, 8'h10);
        @(negedge clk); dsr_n = 1'b0; wait_clk(4);
        reg_rd(3'd6, d, dd); chk("R3 dsr change", d, 8'h32);
        @(negedge clk); dcd_n = 1'b0; wait_clk(4);
        reg_rd(3'd6, d, dd); chk("R2 dcd level", d, 8'hB8);
        @(negedge clk); ri_n = 1'b0; wait_clk(4);
        reg_rd(3'd6, d, dd); chk("R4 ri leading no flag", d, 8'hF0);
        @(negedge clk); ri_n = 1'b1; wait_clk(4);
        reg_rd(3'd6, d, dd); chk("R4 ri trailing", d, 8'hB4);
        @(negedge clk); cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1; wait_clk(4);
        reg_rd(3'd6, d, dd); chk("R3 release edges", d, 8'h0B);
        chk("R7 tx_permit off", {7'd0, tx_permit}, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] d; logic dd;
        msi_en = 1'b0;
        @(negedge clk); dsr_n = 1'b0; wait_clk(4);
        chk("R6 no irq when disabled", {7'd0, msi_req}, 8'h00);
        reg_rd(3'd6, d, dd);
        msi_en = 1'b1;
        @(negedge clk); dcd_n = 1'b0; wait_clk(4);
        chk("R6 dcd irq", {7'd0, msi_req}, 8'h01);
        wait_clk(5);
        chk("R11 irq held", {7'd0, msi_req}, 8'h01);
        cs_c_n = 1'b1;
        reg_rd(3'd6, d, dd);
        chk("R9 unselected read data", d, 8'h00);
        chk("R10 unselected drv_dis", {7'd0, dd}, 8'h00);
        chk("R9 irq kept", {7'd0, msi_req}, 8'h01);
        cs_c_n = 1'b0;
        reg_rd(3'd6, d, dd);
        chk("R9 flag kept across unselected read", d, 8'hA8);
        chk("R5 irq cleared", {7'd0, msi_req}, 8'h00);
        @(negedge clk); ri_n = 1'b0; wait_clk(4);
        chk("R6 ri leading no irq", {7'd0, msi_req}, 8'h00);
        @(negedge clk); ri_n = 1'b1; wait_clk(4);
        chk("R6 ri trailing irq", {7'd0, msi_req}, 8'h01);
        @(negedge clk); dsr_n = 1'b1; dcd_n = 1'b1; wait_clk(4);
        reg_rd(3'd6, d, dd);
        msi_en = 1'b0;
    endtask

    task automatic t_autocts;
        logic [7:0] d; logic dd;
        msi_en = 1'b1; auto_cts_en = 1'b1;
        @(negedge clk); cts_n = 1'b0; wait_clk(4);
        chk("R7 cts masked", {7'd0, msi_req}, 8'h00);
        reg_rd(3'd6, d, dd); chk("R7 cts flag still set", d, 8'h11);
        auto_cts_en = 1'b0;
        @(negedge clk); cts_n = 1'b1; wait_clk(4);
        chk("R7 cts irq", {7'd0, msi_req}, 8'h01);
        reg_rd(3'd6, d, dd);
        msi_en = 1'b0;
    endtask

    task automatic t_ctrl;
        logic [7:0] d; logic dd;
        reg_wr(3'd4, 8'h01); #1;
        chk("R8 dtr active", {7'd0, dtr_n}, 8'h00);
        reg_rd(3'd4, d, dd); chk("R8 ctrl read", d, 8'h01);
        reg_wr(3'd4, 8'h11); #1;
        chk("R8 loop forces dtr", {7'd0, dtr_n}, 8'h01);
        chk("R8 loop_mode", {7'd0, loop_mode}, 8'h01);
        reg_wr(3'd4, 8'hFF);
        reg_rd(3'd4, d, dd); chk("R8 upper bits zero", d, 8'h1F);
        cs_a = 1'b0; reg_wr(3'd4, 8'h00); cs_a = 1'b1;
        reg_rd(3'd4, d, dd); chk("R9 unselected write", d, 8'h1F);
        cs_b = 1'b0; reg_rd(3'd4, d, dd); cs_b = 1'b1;
        chk("R9 unselected read", d, 8'h00);
        reg_wr(3'd6, 8'hFF);
        reg_rd(3'd6, d, dd); chk("R12 status write ignored", d, 8'h00);
        reg_rd(3'd2, d, dd); chk("R12 other addr", d, 8'h00);
        reg_wr(3'd4, 8'h01);
        rst_n = 1'b0; wait_clk(2); rst_n = 1'b1; #1;
        chk("R1 reset clears dtr", {7'd0, dtr_n}, 8'h01);
        reg_rd(3'd4, d, dd); chk("R1 reset clears ctrl", d, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_levels();
        t_irq();
        t_autocts();
        t_ctrl();
        finish_run();
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule